// File: doc/BRIEF.md
# Bank Reactivation Timer

This block keeps the timing state of one DRAM bank for a memory controller. It takes one-cycle command strobes for activate, write and read, plus an auto-precharge flag that comes from column address bit 10 of the write. It drives `bank_ready` high in every cycle in which an activate to this bank would be legal.

A write with auto-precharge closes the row by itself. The write latency runs first, then the burst, whose data takes half as many clock cycles as its beat count because data moves on both clock edges. Write recovery follows, then the internal precharge. The bank may be opened again only when two limits are both met: write recovery plus precharge time counted from the end of the burst, and the row cycle time counted from the previous activate. The later of the two governs.

All timing values are cycle counts on configuration inputs. The block takes them in while the bank is idle. An activate that comes too early sets a sticky violation flag, and so does any command issued while the automatic precharge sequence is running.

Top module: `bank_reactivate_timer`

## Requirements
- R1: After a synchronous active-low reset, `bank_ready` is high and `row_open`, `pchg_busy` and `violation` are low.
- R2: An activate in a cycle where `bank_ready` is high opens the row. From the next cycle on, `row_open` is high and `bank_ready` is low.
- R3: A write with `ap_flag` low leaves the row open: `row_open` stays high, `pchg_busy` stays low and `bank_ready` stays low.
- R4: A write with `ap_flag` high in cycle W drops `row_open` in cycle W+1. Let P = W + WL + BL/2 + tWR, where BL/2 is the burst field shifted right by one. `pchg_busy` is high from cycle P for tRP cycles, and a tRP of 0 counts as 1.
- R5: For an activate in cycle 0 and a write with auto-precharge in cycle W, `bank_ready` first rises in cycle max(tRC, P + tRP). It is never high while `row_open` or `pchg_busy` is high.
- R6: An activate in a cycle where `bank_ready` is low sets `violation` in the next cycle and changes nothing else. `violation` stays high until reset.
- R7: While the auto-precharge sequence runs (after the closing write, until the bank is idle), any activate, write or read sets `violation`. The command is ignored and the sequence timing does not change.
- R8: Timing inputs are taken in only while no row is open or closing. Changing WL, BL, tWR or tRP after the activate does not change the closing sequence.
- R9: More than one command strobe in the same cycle, while idle or with the row open, sets `violation`. The strobes are ignored.
- R10: Reads to an open row, whatever the value of `ap_flag`, do not change the state or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_act | input | 1 | Activate strobe for this bank |
| cmd_wr | input | 1 | Write strobe for this bank |
| cmd_rd | input | 1 | Read strobe for this bank |
| ap_flag | input | 1 | Auto-precharge request (address bit 10) with the write |
| cfg_trc | input | CW | Row cycle time in cycles |
| cfg_twr | input | CW | Write recovery time in cycles |
| cfg_trp | input | CW | Precharge time in cycles |
| cfg_wl | input | CW | Write latency in cycles |
| cfg_bl | input | CW | Burst length in beats |
| bank_ready | output | 1 | An activate is legal in this cycle |
| row_open | output | 1 | Row is open and no close has started |
| pchg_busy | output | 1 | Internal precharge in progress |
| violation | output | 1 | Sticky timing-violation flag |

## Verification
The bench sweeps WL, tWR, tRP, both burst lengths, a short and a long row cycle time, and two write gaps. In each cycle it compares every output with arithmetic expectations, which catches any off-by-one in the latency, burst or recovery count: such an error moves the precharge window or the ready edge by one cycle. Cases with a long tRC catch a design that lets the end of the precharge alone re-enable the bank. Directed runs change the timing inputs after the activate, issue reads in the open row and during the close, issue stacked strobes and early activates, and write without auto-precharge. A design that re-samples its configuration, reacts to an ignored command, closes the row on a plain write or loses the sticky flag would show a shifted edge, a changed state or a wrong `violation` level.

// File: rtl/bart_pkg.sv
package bart_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ROW    = 2'd1,
        PH_APWAIT = 2'd2,
        PH_PRECH  = 2'd3
    } phase_e;
endpackage

// File: rtl/bart_cfg_reg.sv
module bart_cfg_reg #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [CW-1:0] twr_in,
    input  logic [CW-1:0] trp_in,
    input  logic [CW-1:0] wl_in,
    input  logic [CW-1:0] bl_in,
    output logic [CW-1:0] twr_q,
    output logic [CW-1:0] trp_q,
    output logic [CW-1:0] wl_q,
    output logic [CW-1:0] bl_q
);
    typedef struct packed {
        logic [CW-1:0] twr;
        logic [CW-1:0] trp;
        logic [CW-1:0] wl;
        logic [CW-1:0] bl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (capture) begin
            cfg_d.twr = twr_in;
            cfg_d.trp = trp_in;
            cfg_d.wl  = wl_in;
            cfg_d.bl  = bl_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign twr_q = cfg_q.twr;
    assign trp_q = cfg_q.trp;
    assign wl_q  = cfg_q.wl;
    assign bl_q  = cfg_q.bl;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/bart_countdown.sv
module bart_countdown #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                cnt_d.cnt = load_val;
        else if (cnt_q.cnt != 0) cnt_d.cnt = cnt_q.cnt - W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q.cnt == '0);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero); // R5
endmodule

// File: rtl/bart_phase_fsm.sv
module bart_phase_fsm
    import bart_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_act,
    input  logic   cmd_wr,
    input  logic   cmd_rd,
    input  logic   ap_flag,
    input  logic   trc_zero,
    input  logic   ph_zero,
    output phase_e phase,
    output logic   ready,
    output logic   viol,
    output logic   trc_load,
    output logic   ph_load,
    output logic   ph_pick_prech
);
    typedef struct packed {
        phase_e phase;
        logic   viol;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] n_cmd;
    logic       any_cmd;
    logic       multi_cmd;
    logic       ready_c;

    always_comb begin
        n_cmd         = {1'b0, cmd_act} + {1'b0, cmd_wr} + {1'b0, cmd_rd};
        any_cmd       = (n_cmd != 2'd0);
        multi_cmd     = (n_cmd > 2'd1);
        ready_c       = (st_q.phase == PH_IDLE) && trc_zero;
        st_d          = st_q;
        trc_load      = 1'b0;
        ph_load       = 1'b0;
        ph_pick_prech = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (multi_cmd) begin
                    st_d.viol = 1'b1;
                end else if (cmd_act) begin
                    if (ready_c) begin
                        st_d.phase = PH_ROW;
                        trc_load   = 1'b1;
                    end else begin
                        st_d.viol = 1'b1;
                    end
                end
            end
            PH_ROW: begin
                if (multi_cmd || cmd_act) begin
                    st_d.viol = 1'b1;
                end else if (cmd_wr && ap_flag) begin
                    st_d.phase = PH_APWAIT;
                    ph_load    = 1'b1;
                end
            end
            PH_APWAIT: begin
                if (any_cmd) st_d.viol = 1'b1;
                if (ph_zero) begin
                    st_d.phase    = PH_PRECH;
                    ph_load       = 1'b1;
                    ph_pick_prech = 1'b1;
                end
            end
            PH_PRECH: begin
                if (any_cmd) st_d.viol = 1'b1;
                if (ph_zero) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, viol: 1'b0};
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign viol  = st_q.viol;
    assign ready = ready_c;

    AST_EARLY_ACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && !ready) |=> viol); // R6
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol); // R6
    AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && ready && !multi_cmd) |=> (phase == PH_ROW) && !ready); // R2
    AST_AP_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_APWAIT || phase == PH_PRECH) && any_cmd) |=> viol); // R7
    AST_MULTI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        multi_cmd |=> viol); // R9
endmodule

// File: rtl/bank_reactivate_timer.sv
module bank_reactivate_timer
    import bart_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_act,
    input  logic          cmd_wr,
    input  logic          cmd_rd,
    input  logic          ap_flag,
    input  logic [CW-1:0] cfg_trc,
    input  logic [CW-1:0] cfg_twr,
    input  logic [CW-1:0] cfg_trp,
    input  logic [CW-1:0] cfg_wl,
    input  logic [CW-1:0] cfg_bl,
    output logic          bank_ready,
    output logic          row_open,
    output logic          pchg_busy,
    output logic          violation
);
    localparam int PW = CW + 2;

    phase_e        phase;
    logic          trc_zero, ph_zero;
    logic          trc_load, ph_load, ph_pick_prech;
    logic [CW-1:0] twr_q, trp_q, wl_q, bl_q;
    logic [PW-1:0] wait_len, wait_val, prech_val, ph_val;
    logic [CW-1:0] trc_val;

    bart_cfg_reg #(.CW(CW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (phase == PH_IDLE),
        .twr_in  (cfg_twr),
        .trp_in  (cfg_trp),
        .wl_in   (cfg_wl),
        .bl_in   (cfg_bl),
        .twr_q   (twr_q),
        .trp_q   (trp_q),
        .wl_q    (wl_q),
        .bl_q    (bl_q)
    );

    always_comb begin
        wait_len  = PW'(wl_q) + PW'(bl_q >> 1) + PW'(twr_q);
        wait_val  = (wait_len >= PW'(2)) ? wait_len - PW'(2) : '0;
        prech_val = (trp_q != '0) ? PW'(trp_q - CW'(1)) : '0;
        ph_val    = ph_pick_prech ? prech_val : wait_val;
        trc_val   = (cfg_trc != '0) ? cfg_trc - CW'(1) : '0;
    end

    bart_countdown #(.W(CW)) u_trc_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trc_load),
        .load_val (trc_val),
        .zero     (trc_zero)
    );

    bart_countdown #(.W(PW)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    bart_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_act       (cmd_act),
        .cmd_wr        (cmd_wr),
        .cmd_rd        (cmd_rd),
        .ap_flag       (ap_flag),
        .trc_zero      (trc_zero),
        .ph_zero       (ph_zero),
        .phase         (phase),
        .ready         (bank_ready),
        .viol          (violation),
        .trc_load      (trc_load),
        .ph_load       (ph_load),
        .ph_pick_prech (ph_pick_prech)
    );

    assign row_open  = (phase == PH_ROW);
    assign pchg_busy = (phase == PH_PRECH);

    AST_READY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ready |-> (!row_open && !pchg_busy)); // R5
    AST_PLAIN_WR_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && cmd_wr && !ap_flag && !cmd_act && !cmd_rd) |=> row_open); // R3
    AST_READ_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (row_open && cmd_rd && !cmd_act && !cmd_wr) |=> row_open); // R10
    AST_PRECH_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pchg_busy) |-> !$past(row_open) && !$past(bank_ready)); // R4
endmodule

// File: tb/tb_bank_reactivate_timer.sv
module tb_bank_reactivate_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_act = 1'b0, cmd_wr = 1'b0, cmd_rd = 1'b0, ap_flag = 1'b0;
    logic [4:0] cfg_trc = 5'd3, cfg_twr = 5'd2, cfg_trp = 5'd3, cfg_wl = 5'd2, cfg_bl = 5'd4;
    logic       bank_ready, row_open, pchg_busy, violation;
    int         total = 0;
    int         fails = 0;

    always #5 clk = ~clk;

    bank_reactivate_timer dut (
        .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .ap_flag(ap_flag), .cfg_trc(cfg_trc), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
        .cfg_wl(cfg_wl), .cfg_bl(cfg_bl), .bank_ready(bank_ready), .row_open(row_open),
        .pchg_busy(pchg_busy), .violation(violation)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_cmds();
        cmd_act = 1'b0; cmd_wr = 1'b0; cmd_rd = 1'b0; ap_flag = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle_cmds(); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 100; i++) begin
            if (bank_ready) break;
            @(negedge clk);
        end
    endtask

    // mode 0: plain, 1: timing inputs changed after activate (R8),
    // 2: reads with ap_flag high in open row (R10), 3: read during close (R7)
    task automatic run_case(input int wl, input int bl, input int twr, input int trp,
                            input int trc, input int gap, input int mode);
        int p, e, tr;
        tr = (trp == 0) ? 1 : trp;
        p  = gap + wl + bl / 2 + twr;
        e  = (trc > p + tr) ? trc : p + tr;
        wait_ready();
        cfg_wl = 5'(wl); cfg_bl = 5'(bl); cfg_twr = 5'(twr); cfg_trp = 5'(trp); cfg_trc = 5'(trc);
        cmd_act = 1'b1;
        for (int t = 1; t <= e + 1; t++) begin
            @(negedge clk);
            idle_cmds();
            if (mode == 1) begin
                cfg_wl = 5'd9; cfg_bl = 5'd8; cfg_twr = 5'd7; cfg_trp = 5'd6;
            end
            chk((mode == 1) ? "R8" : "R4", "row_open", int'(row_open), (t <= gap) ? 1 : 0);
            chk((mode == 1) ? "R8" : "R4", "pchg_busy", int'(pchg_busy),
                (t >= p && t < p + tr) ? 1 : 0);
            chk((mode == 2) ? "R10" : "R5", "bank_ready", int'(bank_ready), (t >= e) ? 1 : 0);
            if (mode == 3 && t == gap + 2)
                chk("R7", "violation after read in close", int'(violation), 1);
            if (t == gap) begin
                cmd_wr = 1'b1; ap_flag = 1'b1;
            end else if (mode == 2 && t < gap) begin
                cmd_rd = 1'b1; ap_flag = 1'b1;
            end else if (mode == 3 && t == gap + 1) begin
                cmd_rd = 1'b1;
            end
        end
        idle_cmds();
    endtask

    initial begin
        #1_900_000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "bank_ready", int'(bank_ready), 1);
        chk("R1", "row_open", int'(row_open), 0);
        chk("R1", "pchg_busy", int'(pchg_busy), 0);
        chk("R1", "violation", int'(violation), 0);

        // Sweep of the closing sequence (R4, R5)
        for (int bl = 4; bl <= 8; bl += 4)
            for (int wl = 1; wl <= 4; wl++)
                for (int twr = 0; twr <= 3; twr++)
                    for (int trp = 1; trp <= 3; trp++)
                        for (int ti = 0; ti < 2; ti++)
                            for (int gap = 1; gap <= 2; gap++)
                                run_case(wl, bl, twr, trp, (ti == 1) ? 20 : 3, gap, 0);
        // Worked case: WL=4, tWR=2, BL=4, tRP=3, write one cycle after activate
        run_case(4, 4, 2, 3, 3, 1, 0);
        run_case(2, 4, 2, 3, 3, 1, 1);
        run_case(1, 8, 1, 2, 4, 3, 2);
        chk("R10", "violation after reads", int'(violation), 0);
        chk("R8", "violation after cfg change", int'(violation), 0);

        // R2 and R3: activate opens the row, plain write keeps it open
        wait_ready();
        cfg_trc = 5'd2; cfg_wl = 5'd1; cfg_bl = 5'd4; cfg_twr = 5'd0; cfg_trp = 5'd1;
        cmd_act = 1'b1;
        @(negedge clk); idle_cmds();
        chk("R2", "row_open", int'(row_open), 1);
        chk("R2", "bank_ready", int'(bank_ready), 0);
        cmd_wr = 1'b1; ap_flag = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk); idle_cmds();
            chk("R3", "row_open", int'(row_open), 1);
            chk("R3", "pchg_busy", int'(pchg_busy), 0);
            chk("R3", "bank_ready", int'(bank_ready), 0);
        end
        chk("R3", "violation", int'(violation), 0);

        // R9: stacked strobes in open row are flagged and ignored
        cmd_wr = 1'b1; cmd_rd = 1'b1; ap_flag = 1'b1;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk); idle_cmds();
            chk("R9", "row_open", int'(row_open), 1);
            chk("R9", "pchg_busy", int'(pchg_busy), 0);
            chk("R9", "violation", int'(violation), 1);
        end
        do_reset();
        chk("R6", "violation cleared by reset", int'(violation), 0);
        chk("R1", "bank_ready after reset", int'(bank_ready), 1);

        // R6: activate on an open row
        cmd_act = 1'b1;
        @(negedge clk);
        chk("R6", "violation before early act", int'(violation), 0);
        @(negedge clk); idle_cmds();
        chk("R6", "violation after early act", int'(violation), 1);
        chk("R6", "row_open unchanged", int'(row_open), 1);
        for (int t = 0; t < 10; t++) @(negedge clk);
        chk("R6", "violation sticky", int'(violation), 1);
        do_reset();
        chk("R6", "violation cleared", int'(violation), 0);

        // R6: activate while idle but row cycle limit not met
        cfg_trc = 5'd20; cfg_wl = 5'd1; cfg_bl = 5'd4; cfg_twr = 5'd0; cfg_trp = 5'd1;
        cmd_act = 1'b1;
        for (int t = 1; t <= 20; t++) begin
            @(negedge clk); idle_cmds();
            if (t == 1) begin cmd_wr = 1'b1; ap_flag = 1'b1; end
            if (t == 8) begin
                chk("R6", "ready before tRC", int'(bank_ready), 0);
                cmd_act = 1'b1;
            end
            if (t == 9) begin
                chk("R6", "violation early act idle", int'(violation), 1);
                chk("R6", "early act ignored", int'(row_open), 0);
            end
            if (t == 20) chk("R6", "ready at tRC", int'(bank_ready), 1);
        end
        do_reset();

        // R7: read during the close is flagged and does not shift timing
        run_case(3, 4, 2, 2, 3, 1, 3);
        chk("R7", "violation sticky after close", int'(violation), 1);
        do_reset();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule